// File: doc/BRIEF.md
# AC-link codec input frame generator

This block sits on the codec side of an AC'97-style serial link. It builds the frame that the codec returns to the controller and shifts it out one bit per bit clock. A frame is 256 bits: a 16-bit tag phase followed by twelve 20-bit slots. A rising edge on the frame sync input starts a frame.

When a frame starts, the block takes a snapshot of its inputs. These are the codec-ready state, the decoded command of the previous frame (read request, register address, read data and whether the register exists), the slot-request flags, the ADC sample and its valid strobe, and the auxiliary-slot routing. From that snapshot it forms the tag bits and the slot contents. Status slots carry data only as the reply to a read seen one frame earlier. The sample tags follow on-demand sample availability.

Top module: `aclink_in_framer`

Positions below are frame bit indices, 255 = first bit sent. Tag bit t is frame bit 240+t. Bit b of slot n (1..12) is frame bit 240-20n+b.

## Requirements
- R1: A rising edge of sync_i sampled on clock edge k starts a frame. Tag bit 15 (frame bit 255) appears on sdata_o after edge k+1, and the following bits come MSB first, one per edge, for 256 bits in total. With no frame in progress, and in reset, sdata_o is 0. A new sync rising edge restarts the frame at once.
- R2: Tag bit 15 equals ready_i. When ready_i is 0, all 256 bits of the frame are 0.
- R3: Tag bits 8..4 and 2..0 are always 0, and slot 4 is always all zeros.
- R4: With rd_req_i at 1, tag bits 14 and 13 are 1, slot 1 bits 18..12 carry rd_addr_i, and slot 2 bits 19..4 carry the read data with bits 3..0 at 0. With rd_req_i at 0, tag bits 14 and 13 are 0, slot 2 is zero, and slot 1 is zero apart from bits 11..10. Slot 1 bit 19 and bits 9..0 are always 0.
- R5: A read of an odd address, or of a register whose reg_impl_i is 0, still sets tag bits 14 and 13 and returns the address, and slot 2 carries 0000h as its data.
- R6: Slot 1 bits 11 and 10 carry slot_req_i[1] and slot_req_i[0], whatever the value of rd_req_i.
- R7: Tag bits 12 and 11 both equal adc_valid_i. Slot 3 carries the left-justified sample when adc_valid_i is 1 and zero otherwise.
- R8: When adc_route_i is nonzero and aux_en_i is 1, aux_sel_i selects one auxiliary slot: 0 selects slot 5 and tag bit 10, 1 selects slot 6 and tag bit 9, 2 selects slot 12 and tag bit 3, and 3 selects none. The selected tag bit is 1 and the selected slot carries aux_data_i. Every other slot from 5 to 12, and its tag bit, is 0.
- R9: Inputs are taken only at the frame-start edge. Changes to them during the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync; a rising edge starts a frame |
| ready_i | input | 1 | Codec ready |
| rd_req_i | input | 1 | Previous frame carried a read command |
| rd_addr_i | input | 7 | Register address of that read |
| reg_data_i | input | 16 | Register read data |
| reg_impl_i | input | 1 | Addressed register is implemented |
| slot_req_i | input | 2 | Slot-request flags for slot 1 bits 11..10 |
| adc_valid_i | input | 1 | A new ADC sample is available for this frame |
| adc_data_i | input | ADC_W | ADC left sample |
| adc_route_i | input | 2 | ADC routing control; nonzero enables routing |
| aux_en_i | input | 1 | Auxiliary-slot enable |
| aux_sel_i | input | 2 | Auxiliary slot select |
| aux_data_i | input | 20 | Auxiliary slot data |
| sdata_o | output | 1 | Serial input-frame data toward the controller |

## Verification
The assertions check on every cycle:
- the line stays quiet between frames and in frames sent while the codec is not ready;
- tag bit 15 and the status tags match the inputs latched at frame start;
- the reserved tag bits and slot 4 stay zero;
- the status slots stay empty when no read came before;
- the selected auxiliary tag is set.

Only the bench scenarios show the following: the actual address, read data, sample and auxiliary payloads in their bit positions, the zero data returned for odd or unimplemented registers, the sample tags following the valid strobe, the restart on an early sync, and the fact that changes to the inputs in mid-frame have no effect.

// File: rtl/aclink_in_pkg.sv
package aclink_in_pkg;
  localparam int TAG_W    = 16;
  localparam int SLOT_W   = 20;
  localparam int N_SLOTS  = 12;
  localparam int FRAME_W  = TAG_W + N_SLOTS * SLOT_W;
  localparam int TAG_BASE = FRAME_W - TAG_W;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 16;

  typedef enum logic [1:0] {
    AUX_S5   = 2'd0,
    AUX_S6   = 2'd1,
    AUX_S12  = 2'd2,
    AUX_NONE = 2'd3
  } aux_sel_e;

  typedef struct packed {
    logic              rdy;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rdata;
    logic              impl;
    logic [1:0]        sreq;
    logic              adc_v;
    logic [SLOT_W-1:0] adc;
    logic              aux_on;
    logic [1:0]        aux_sel;
    logic [SLOT_W-1:0] aux;
  } frame_req_t;

  // frame bit index of slot n's LSB, slot 1 follows the tag phase
  function automatic int slot_lsb(int n);
    return TAG_BASE - SLOT_W * n;
  endfunction
endpackage

// File: rtl/aclink_sync_detect.sv
module aclink_sync_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic start_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign start_o = sync_i & ~sync_q;
endmodule

// File: rtl/aclink_tag_gen.sv
module aclink_tag_gen
  import aclink_in_pkg::*;
(
  input  logic             rdy_i,
  input  logic             rd_i,
  input  logic             adc_v_i,
  input  logic             aux_on_i,
  input  logic [1:0]       aux_sel_i,
  output logic [TAG_W-1:0] tag_o
);
  always_comb begin
    tag_o = '0;
    if (rdy_i) begin
      tag_o[15] = 1'b1;
      tag_o[14] = rd_i;
      tag_o[13] = rd_i;
      tag_o[12] = adc_v_i;
      tag_o[11] = adc_v_i;
      if (aux_on_i) begin
        case (aux_sel_i)
          AUX_S5:  tag_o[10] = 1'b1;
          AUX_S6:  tag_o[9]  = 1'b1;
          AUX_S12: tag_o[3]  = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/aclink_slot_fill.sv
module aclink_slot_fill
  import aclink_in_pkg::*;
(
  input  frame_req_t                  req_i,
  output logic [N_SLOTS*SLOT_W-1:0]   slots_o
);
  logic [DATA_W-1:0] data_eff;
  // odd or missing registers answer with zero data
  assign data_eff = (req_i.impl && !req_i.addr[0]) ? req_i.rdata : '0;

  for (genvar n = 1; n <= N_SLOTS; n++) begin : g_slot
    localparam int LSB = slot_lsb(n);
    logic [SLOT_W-1:0] val;

    if (n == 1) begin : g_addr
      assign val = req_i.rdy ?
        {1'b0, (req_i.rd ? req_i.addr : {ADDR_W{1'b0}}), req_i.sreq, 10'b0} : '0;
    end else if (n == 2) begin : g_data
      assign val = (req_i.rdy && req_i.rd) ? {data_eff, 4'b0} : '0;
    end else if (n == 3) begin : g_adc
      assign val = (req_i.rdy && req_i.adc_v) ? req_i.adc : '0;
    end else if (n == 5 || n == 6 || n == 12) begin : g_aux
      localparam logic [1:0] CODE = (n == 5) ? AUX_S5 : ((n == 6) ? AUX_S6 : AUX_S12);
      assign val = (req_i.rdy && req_i.aux_on && req_i.aux_sel == CODE) ? req_i.aux : '0;
    end else begin : g_zero
      assign val = '0;
    end

    assign slots_o[LSB +: SLOT_W] = val;
  end
endmodule

// File: rtl/aclink_shifter.sv
module aclink_shifter
  import aclink_in_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   left_q;
  logic               sdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      left_q  <= '0;
      sdata_q <= 1'b0;
    end else begin
      // last bit of the old frame still leaves on a restart edge
      sdata_q <= (left_q != '0) & shreg_q[FRAME_W-1];
      if (load_i) begin
        shreg_q <= frame_i;
        left_q  <= CNT_W'(FRAME_W);
      end else if (left_q != '0) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        left_q  <= left_q - CNT_W'(1);
      end
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/aclink_in_framer.sv
module aclink_in_framer
  import aclink_in_pkg::*;
#(
  parameter int ADC_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ready_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic              reg_impl_i,
  input  logic [1:0]        slot_req_i,
  input  logic              adc_valid_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic [1:0]        adc_route_i,
  input  logic              aux_en_i,
  input  logic [1:0]        aux_sel_i,
  input  logic [SLOT_W-1:0] aux_data_i,
  output logic              sdata_o
);
  logic                      start;
  logic [SLOT_W-1:0]         adc_just;
  logic [TAG_W-1:0]          tag;
  logic [N_SLOTS*SLOT_W-1:0] slots;
  frame_req_t                req;

  if (ADC_W == SLOT_W) begin : g_adc_full
    assign adc_just = adc_data_i;
  end else begin : g_adc_pad
    assign adc_just = {adc_data_i, {(SLOT_W-ADC_W){1'b0}}};
  end

  assign req.rdy     = ready_i;
  assign req.rd      = rd_req_i;
  assign req.addr    = rd_addr_i;
  assign req.rdata   = reg_data_i;
  assign req.impl    = reg_impl_i;
  assign req.sreq    = slot_req_i;
  assign req.adc_v   = adc_valid_i;
  assign req.adc     = adc_just;
  assign req.aux_on  = (|adc_route_i) & aux_en_i;
  assign req.aux_sel = aux_sel_i;
  assign req.aux     = aux_data_i;

  aclink_sync_detect u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .start_o (start)
  );

  aclink_tag_gen u_tag (
    .rdy_i     (req.rdy),
    .rd_i      (req.rd),
    .adc_v_i   (req.adc_v),
    .aux_on_i  (req.aux_on),
    .aux_sel_i (req.aux_sel),
    .tag_o     (tag)
  );

  aclink_slot_fill u_fill (
    .req_i   (req),
    .slots_o (slots)
  );

  aclink_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .frame_i ({tag, slots}),
    .sdata_o (sdata_o)
  );
endmodule

// File: rtl/aclink_in_framer_chk.sv
module aclink_in_framer_chk
  import aclink_in_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_i,
  input logic       ready_i,
  input logic       rd_req_i,
  input logic [1:0] adc_route_i,
  input logic       aux_en_i,
  input logic [1:0] aux_sel_i,
  input logic       sdata_o
);
  localparam int S1 = slot_lsb(1);
  localparam int S2 = slot_lsb(2);
  localparam int S4 = slot_lsb(4);

  logic       sync_q, start;
  logic [8:0] left;
  logic       snap_rdy, snap_rd, snap_aux;
  logic [1:0] snap_sel;
  logic       out_on, frm_rdy, frm_rd, frm_aux;
  logic [1:0] frm_sel;
  int         out_idx;
  int         aux_idx;

  assign start = sync_i & ~sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0; left <= '0; out_on <= 1'b0; out_idx <= 0;
      snap_rdy <= 1'b0; snap_rd <= 1'b0; snap_aux <= 1'b0; snap_sel <= '0;
      frm_rdy <= 1'b0; frm_rd <= 1'b0; frm_aux <= 1'b0; frm_sel <= '0;
    end else begin
      sync_q  <= sync_i;
      out_on  <= (left != '0);
      out_idx <= int'(left) - 1;
      frm_rdy <= snap_rdy; frm_rd <= snap_rd; frm_aux <= snap_aux; frm_sel <= snap_sel;
      if (start) begin
        left     <= 9'(FRAME_W);
        snap_rdy <= ready_i;
        snap_rd  <= rd_req_i;
        snap_aux <= (adc_route_i != 2'b00) && aux_en_i;
        snap_sel <= aux_sel_i;
      end else if (left != '0) begin
        left <= left - 9'd1;
      end
    end
  end

  assign aux_idx = (frm_sel == 2'd0) ? TAG_BASE + 10 :
                   (frm_sel == 2'd1) ? TAG_BASE + 9  :
                   (frm_sel == 2'd2) ? TAG_BASE + 3  : -1;

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_on |-> !sdata_o);

  a_r2_ready_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_on && out_idx == FRAME_W - 1) |-> (sdata_o == frm_rdy));

  a_r2_not_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_on && !frm_rdy) |-> !sdata_o);

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_on && ((out_idx >= TAG_BASE + 4 && out_idx <= TAG_BASE + 8) ||
                (out_idx >= TAG_BASE && out_idx <= TAG_BASE + 2) ||
                (out_idx >= S4 && out_idx < S4 + SLOT_W))) |-> !sdata_o);

  a_r4_status_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_on && (out_idx == TAG_BASE + 14 || out_idx == TAG_BASE + 13)) |->
    (sdata_o == (frm_rdy && frm_rd)));

  a_r4_no_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_on && !frm_rd && out_idx >= S2 && out_idx < S1 + SLOT_W &&
     out_idx != S1 + 10 && out_idx != S1 + 11) |-> !sdata_o);

  a_r8_aux_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_on && frm_rdy && frm_aux && out_idx == aux_idx) |-> sdata_o);
endmodule

bind aclink_in_framer aclink_in_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .ready_i     (ready_i),
  .rd_req_i    (rd_req_i),
  .adc_route_i (adc_route_i),
  .aux_en_i    (aux_en_i),
  .aux_sel_i   (aux_sel_i),
  .sdata_o     (sdata_o)
);

// File: tb/aclink_in_framer_test.sv
`timescale 1ns/1ps
module aclink_in_framer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0, ready = 1'b0, rd_req = 1'b0, impl = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] rdata = '0;
  logic [1:0]  sreq = '0, route = '0, sel = '0;
  logic        adc_v = 1'b0, aux_en = 1'b0;
  logic [19:0] adc = '0, aux = '0;
  logic        sdata;

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  aclink_in_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .ready_i(ready),
    .rd_req_i(rd_req), .rd_addr_i(addr), .reg_data_i(rdata), .reg_impl_i(impl),
    .slot_req_i(sreq), .adc_valid_i(adc_v), .adc_data_i(adc),
    .adc_route_i(route), .aux_en_i(aux_en), .aux_sel_i(sel),
    .aux_data_i(aux), .sdata_o(sdata)
  );

  function automatic int sb(int n, int b);
    return 240 - 20 * n + b;
  endfunction

  function automatic logic [255:0] build();
    logic [255:0] f = '0;
    logic [15:0] d;
    int n, t;
    if (!ready) return f;
    f[255] = 1'b1;
    f[sb(1,10)] = sreq[0];
    f[sb(1,11)] = sreq[1];
    if (rd_req) begin
      f[254] = 1'b1; f[253] = 1'b1;
      for (int b = 0; b < 7; b++) f[sb(1,12+b)] = addr[b];
      d = (impl && !addr[0]) ? rdata : 16'h0;
      for (int b = 0; b < 16; b++) f[sb(2,4+b)] = d[b];
    end
    if (adc_v) begin
      f[252] = 1'b1; f[251] = 1'b1;
      for (int b = 0; b < 20; b++) f[sb(3,b)] = adc[b];
    end
    if (route != 0 && aux_en && sel != 3) begin
      n = (sel == 0) ? 5 : (sel == 1) ? 6 : 12;
      t = (sel == 0) ? 10 : (sel == 1) ? 9 : 3;
      f[240+t] = 1'b1;
      for (int b = 0; b < 20; b++) f[sb(n,b)] = aux[b];
    end
    return f;
  endfunction

  function automatic string lab(int i, bit r);
    if (!r || i == 255) return "R2";
    if (i == 254 || i == 253) return "R4";
    if (i == 252 || i == 251) return "R7";
    if (i == 250 || i == 249 || i == 243) return "R8";
    if (i >= 240) return "R3";
    if (i >= 220) return (i == 230 || i == 231) ? "R6" : "R4";
    if (i >= 200) return "R4";
    if (i >= 180) return "R7";
    if (i >= 160) return "R3";
    return "R8";
  endfunction

  // behavioural model: bit queue refilled on each sync rise
  bit    qb[$];
  string lq[$];
  logic  exp_bit = 1'b0;
  string exp_lab = "R1";
  logic  sync_m = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qb.delete(); lq.delete();
      exp_bit <= 1'b0; exp_lab <= "R1"; sync_m <= 1'b0;
    end else begin
      bit b; string l;
      logic [255:0] f;
      if (qb.size() > 0) begin b = qb.pop_front(); l = lq.pop_front(); end
      else begin b = 1'b0; l = "R1"; end
      exp_bit <= b; exp_lab <= l;
      if (sync && !sync_m) begin
        qb.delete(); lq.delete();
        f = build();
        for (int i = 255; i >= 0; i--) begin
          qb.push_back(f[i]);
          lq.push_back({lab(i, ready), "/", cur_tag});
        end
      end
      sync_m <= sync;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (sdata !== exp_bit) begin
        n_bad++;
        $display("FAIL %s t=%0t sdata_o actual %b expected %b", exp_lab, $time, sdata, exp_bit);
      end
    end
  end

  task automatic frame(input int len, input bit scramble, input string tag);
    @(negedge clk);
    sync = 1'b1; cur_tag = tag;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == 1 && scramble) begin
        ready = ~ready; rd_req = ~rd_req; addr = ~addr; rdata = ~rdata;
        impl = ~impl; sreq = ~sreq; adc_v = ~adc_v; adc = ~adc;
        route = ~route; aux_en = ~aux_en; sel = ~sel; aux = ~aux;
      end
      if (i == 16) sync = 1'b0;
    end
  endtask

  task automatic setin(input bit r, input bit rd, input logic [6:0] a, input logic [15:0] d,
                       input bit im, input logic [1:0] sq, input bit av, input logic [19:0] ad,
                       input logic [1:0] ro, input bit en, input logic [1:0] s, input logic [19:0] x);
    ready = r; rd_req = rd; addr = a; rdata = d; impl = im; sreq = sq;
    adc_v = av; adc = ad; route = ro; aux_en = en; sel = s; aux = x;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_cmp++;
    if (sdata !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset sdata_o actual %b expected 0", sdata);
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    setin(0, 1, 7'h2C, 16'hBEEF, 1, 2'b11, 1, 20'hFFFFF, 2'b01, 1, 2'd0, 20'hFFFFF);
    frame(256, 0, "R2");
    setin(1, 1, 7'h2C, 16'hBEEF, 1, 2'b10, 1, 20'hA5C3F, 2'b01, 1, 2'd0, 20'h12345);
    frame(256, 0, "R4");
    setin(1, 1, 7'h2D, 16'hFFFF, 1, 2'b01, 0, 20'h0, 2'b10, 1, 2'd1, 20'hCAFE1);
    frame(256, 0, "R5");
    setin(1, 1, 7'h44, 16'h1234, 0, 2'b00, 1, 20'h00F0F, 2'b00, 0, 2'd0, 20'h0);
    frame(256, 0, "R5");
    setin(1, 0, 7'h7F, 16'hFFFF, 1, 2'b11, 0, 20'hFFFFF, 2'b11, 1, 2'd1, 20'h9ABCD);
    frame(256, 0, "R6");
    setin(1, 0, 7'h00, 16'h0, 0, 2'b01, 1, 20'h80001, 2'b10, 1, 2'd2, 20'hF0F0F);
    frame(256, 0, "R8");
    setin(1, 1, 7'h10, 16'h8001, 1, 2'b00, 1, 20'h7FFFE, 2'b01, 1, 2'd3, 20'hFFFFF);
    frame(256, 0, "R8");
    setin(1, 0, 7'h00, 16'h0, 0, 2'b10, 0, 20'h0, 2'b00, 1, 2'd0, 20'hFFFFF);
    frame(256, 0, "R8");
    setin(1, 0, 7'h00, 16'h0, 0, 2'b00, 1, 20'h13579, 2'b10, 0, 2'd2, 20'hFFFFF);
    frame(256, 0, "R7");
    setin(1, 1, 7'h3A, 16'h5AA5, 1, 2'b01, 1, 20'h2468A, 2'b11, 1, 2'd2, 20'h55555);
    frame(256, 1, "R9");
    setin(1, 1, 7'h06, 16'hA5A5, 1, 2'b11, 1, 20'hFFFFF, 2'b01, 1, 2'd0, 20'hFFFFF);
    frame(100, 0, "R1");
    setin(1, 0, 7'h00, 16'h0, 0, 2'b10, 1, 20'hC0FFE, 2'b01, 1, 2'd1, 20'h0F0F0);
    frame(256, 0, "R1");
    repeat (40) @(negedge clk);
    setin(1, 1, 7'h22, 16'h0F0F, 1, 2'b00, 0, 20'h0, 2'b00, 0, 2'd3, 20'h0);
    frame(256, 0, "R1");
    cur_tag = "R1";
    repeat (300) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule